// File: doc/BRIEF.md
# Pipeline Execute Stage with Operand Bypass

This block is the execute stage of a five-stage, 32-bit in-order pipeline. Each cycle it takes the operands read in decode: two register values, a sign-extended immediate and the instruction word. It also watches the two stages ahead of it: the ALU result waiting in the memory stage and the value about to be written back to the register file. When an older instruction is still on its way to writing a source register of the instruction now in execute, the block uses that newer value in place of the stale register value. The younger of the two producers is preferred.

After the bypass step, the second operand is passed on as store data. It is also one of the two candidates for the second ALU input, the other being the immediate. A small decoder turns a 2-bit operation class and the instruction's function field into a 4-bit ALU code. The ALU result and the store data are registered on the rising clock edge and appear at the block's outputs for the memory stage.

Top module: `exec_fwd_stage`

## Requirements
- R1: While `rst` is high at a rising edge, both `res_q` and `store_q` become zero.
- R2: Source A is instruction bits [25:21]. If `mem_we` is high and `mem_dst` equals source A, operand A is `mem_val`. Otherwise, if `wb_we` is high and `wb_dst` equals source A, operand A is `wb_val`. Otherwise operand A is `rs_val`.
- R3: When both later stages write the same source register, the memory-stage value (`mem_val`) is used for that operand.
- R4: A source address of 0 is never bypassed. The register-file value is used even when a later stage writes register 0 with its enable high.
- R5: A later stage whose write enable is low is never used for bypass, even if its destination matches.
- R6: Source B is instruction bits [20:16] and is bypassed by the same rules as source A, giving operand B.
- R7: `store_q` always carries operand B. The second ALU input is `imm` when `use_imm` is high and operand B when it is low.
- R8: `op_class` 00 adds the two ALU inputs and 01 subtracts the second from the first. Class 11 adds.
- R9: `op_class` 10 decodes function bits [5:0]. 0x20 is add, 0x22 is subtract, 0x24 is bitwise AND, 0x25 is bitwise OR, and 0x2A is signed set-less-than, giving 1 or 0. Any other function code adds.
- R10: Outputs change only at a rising edge. They show the result for the inputs present at the previous rising edge and hold while inputs change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rs_val | input | 32 | Register-file value for source A |
| rt_val | input | 32 | Register-file value for source B |
| imm | input | 32 | Sign-extended immediate |
| instr | input | 32 | Instruction word in execute |
| use_imm | input | 1 | Select immediate as second ALU input |
| op_class | input | 2 | ALU operation class |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_val | input | 32 | Memory-stage ALU result |
| wb_we | input | 1 | Write-back instruction writes a register |
| wb_dst | input | 5 | Write-back destination register |
| wb_val | input | 32 | Write-back value |
| res_q | output | 32 | Registered ALU result |
| store_q | output | 32 | Registered bypassed operand B (store data) |

## Verification
Directed patterns model back-to-back dependencies, where only the memory-stage match applies, and a dependency two instructions apart, where only the write-back match applies. They are run on each source in turn, so a bypass wired to the wrong operand shows up. Cases where both stages match the same register, or where the matching destination is register 0 or the write enable is low, separate a correct priority and qualification from one that is reversed or missing. A store with an immediate checks that the address uses the immediate while the store data still takes the bypassed value. Every function code and both fixed classes are run with signed operands, and outputs are sampled just after inputs change to confirm they wait for the clock edge.

// File: rtl/exs_pkg.sv
package exs_pkg;

  typedef enum logic [3:0] {
    FN_AND = 4'b0000,
    FN_OR  = 4'b0001,
    FN_ADD = 4'b0010,
    FN_SUB = 4'b0110,
    FN_SLT = 4'b0111
  } alu_fn_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } byp_sel_e;

  localparam logic [1:0] CLS_ADD   = 2'b00;
  localparam logic [1:0] CLS_SUB   = 2'b01;
  localparam logic [1:0] CLS_FUNCT = 2'b10;

  localparam logic [5:0] FC_ADD = 6'h20;
  localparam logic [5:0] FC_SUB = 6'h22;
  localparam logic [5:0] FC_AND = 6'h24;
  localparam logic [5:0] FC_OR  = 6'h25;
  localparam logic [5:0] FC_SLT = 6'h2A;

endpackage

// File: rtl/byp_select.sv
module byp_select
  import exs_pkg::*;
#(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][AW-1:0] src_addr,
  input  logic                       mem_we,
  input  logic [AW-1:0]              mem_dst,
  input  logic                       wb_we,
  input  logic [AW-1:0]              wb_dst,
  output logic [NUM_SRC-1:0][1:0]    sel
);

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_live, wb_live;

  assign mem_live = mem_we && (mem_dst != ZERO_REG);
  assign wb_live  = wb_we  && (wb_dst  != ZERO_REG);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_comb begin
      if (mem_live && (mem_dst == src_addr[g])) begin
        sel[g] = SRC_MEM;
      end else if (wb_live && (wb_dst == src_addr[g])) begin
        sel[g] = SRC_WB;
      end else begin
        sel[g] = SRC_REG;
      end
    end
  end

endmodule

// File: rtl/byp_mux.sv
module byp_mux
  import exs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] out_val
);

  always_comb begin
    case (sel)
      SRC_MEM: out_val = mem_val;
      SRC_WB:  out_val = wb_val;
      default: out_val = reg_val;
    endcase
  end

endmodule

// File: rtl/alu_decode.sv
module alu_decode
  import exs_pkg::*;
(
  input  logic [1:0] op_class,
  input  logic [5:0] funct,
  output logic [3:0] fn
);

  always_comb begin
    case (op_class)
      CLS_ADD: fn = FN_ADD;
      CLS_SUB: fn = FN_SUB;
      CLS_FUNCT: begin
        case (funct)
          FC_ADD:  fn = FN_ADD;
          FC_SUB:  fn = FN_SUB;
          FC_AND:  fn = FN_AND;
          FC_OR:   fn = FN_OR;
          FC_SLT:  fn = FN_SLT;
          default: fn = FN_ADD;
        endcase
      end
      default: fn = FN_ADD;
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import exs_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    fn,
  output logic [DW-1:0] y
);

  logic lt;

  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (fn)
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_SUB:  y = a - b;
      FN_SLT:  y = {{(DW-1){1'b0}}, lt};
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/exec_fwd_stage.sv
module exec_fwd_stage
  import exs_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] rt_val,
  input  logic [DW-1:0] imm,
  input  logic [IW-1:0] instr,
  input  logic          use_imm,
  input  logic [1:0]    op_class,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_dst,
  input  logic [DW-1:0] mem_val,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_dst,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] res_q,
  output logic [DW-1:0] store_q
);

  localparam int NSRC   = 2;
  localparam int FN_W   = 6;
  localparam int RT_LSB = IW - 6 - 2 * AW;
  localparam int RS_LSB = RT_LSB + AW;

  logic [NSRC-1:0][AW-1:0] src_addr;
  logic [NSRC-1:0][1:0]    sel;
  logic [NSRC-1:0][DW-1:0] reg_vals;
  logic [NSRC-1:0][DW-1:0] opnd;
  logic [FN_W-1:0]         funct;
  logic [3:0]              fn;
  logic [DW-1:0]           alu_b;
  logic [DW-1:0]           alu_y;
  logic                    unused_instr_bits;

  assign src_addr[0] = instr[RS_LSB +: AW];
  assign src_addr[1] = instr[RT_LSB +: AW];
  assign funct       = instr[FN_W-1:0];
  assign reg_vals[0] = rs_val;
  assign reg_vals[1] = rt_val;
  assign unused_instr_bits = ^{instr[IW-1:RS_LSB+AW], instr[RT_LSB-1:FN_W]};

  byp_select #(.AW(AW), .NUM_SRC(NSRC)) u_sel (
    .src_addr (src_addr),
    .mem_we   (mem_we),
    .mem_dst  (mem_dst),
    .wb_we    (wb_we),
    .wb_dst   (wb_dst),
    .sel      (sel)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_mux
    byp_mux #(.DW(DW)) u_mux (
      .sel     (sel[g]),
      .reg_val (reg_vals[g]),
      .mem_val (mem_val),
      .wb_val  (wb_val),
      .out_val (opnd[g])
    );
  end

  assign alu_b = use_imm ? imm : opnd[1];

  alu_decode u_dec (
    .op_class (op_class),
    .funct    (funct),
    .fn       (fn)
  );

  alu_core #(.DW(DW)) u_alu (
    .a  (opnd[0]),
    .b  (alu_b),
    .fn (fn),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      store_q <= '0;
    end else begin
      res_q   <= alu_y;
      store_q <= opnd[1];
    end
  end

endmodule

// File: rtl/exec_fwd_chk.sv
module exec_fwd_chk #(
  parameter int DW = 32,
  parameter int AW = 5,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] rs_val,
  input logic [DW-1:0] rt_val,
  input logic [DW-1:0] imm,
  input logic [IW-1:0] instr,
  input logic          use_imm,
  input logic [1:0]    op_class,
  input logic          mem_we,
  input logic [AW-1:0] mem_dst,
  input logic [DW-1:0] mem_val,
  input logic          wb_we,
  input logic [AW-1:0] wb_dst,
  input logic [DW-1:0] wb_val,
  input logic [DW-1:0] res_q,
  input logic [DW-1:0] store_q
);

  localparam int RT_LSB = IW - 6 - 2 * AW;
  localparam int RS_LSB = RT_LSB + AW;

  logic [AW-1:0] ck_rs, ck_rt;
  assign ck_rs = instr[RS_LSB +: AW];
  assign ck_rt = instr[RT_LSB +: AW];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && store_q == '0));

  // R3
  mem_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && wb_we && ck_rt != '0 && mem_dst == ck_rt && wb_dst == ck_rt)
    |=> store_q == $past(mem_val));

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (ck_rt == '0) |=> store_q == $past(rt_val));

  // R5
  no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we && !wb_we) |=> store_q == $past(rt_val));

  // R6
  wb_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_we && ck_rt != '0 && wb_dst == ck_rt && !(mem_we && mem_dst == ck_rt))
    |=> store_q == $past(wb_val));

  // R8
  imm_add_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we && !wb_we && use_imm && op_class == 2'b00)
    |=> res_q == $past(rs_val + imm));

endmodule

bind exec_fwd_stage exec_fwd_chk #(.DW(DW), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
  .instr(instr), .use_imm(use_imm), .op_class(op_class),
  .mem_we(mem_we), .mem_dst(mem_dst), .mem_val(mem_val),
  .wb_we(wb_we), .wb_dst(wb_dst), .wb_val(wb_val),
  .res_q(res_q), .store_q(store_q)
);

// File: tb/sim_exec_fwd_stage.sv
`timescale 1ns/1ps
module sim_exec_fwd_stage;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] rs_val, rt_val, imm, instr, mem_val, wb_val;
  logic        use_imm, mem_we, wb_we;
  logic [1:0]  op_class;
  logic [4:0]  mem_dst, wb_dst;
  logic [31:0] res_q, store_q;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  exec_fwd_stage u0 (
    .clk(clk), .rst(rst), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
    .instr(instr), .use_imm(use_imm), .op_class(op_class),
    .mem_we(mem_we), .mem_dst(mem_dst), .mem_val(mem_val),
    .wb_we(wb_we), .wb_dst(wb_dst), .wb_val(wb_val),
    .res_q(res_q), .store_q(store_q)
  );

  function automatic logic [31:0] mk(input logic [4:0] s, input logic [4:0] t,
                                     input logic [5:0] f);
    return {6'd0, s, t, 5'd3, 5'd0, f};
  endfunction

  function automatic logic [31:0] pick(input logic [4:0] a, input logic [31:0] r);
    if (a != 0 && mem_we && mem_dst == a) return mem_val;
    if (a != 0 && wb_we && wb_dst == a) return wb_val;
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [5:0] f;
    f = instr[5:0];
    case (op_class)
      2'b01: return a - b;
      2'b10: begin
        case (f)
          6'h22: return a - b;
          6'h24: return a & b;
          6'h25: return a | b;
          6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: return a + b;
        endcase
      end
      default: return a + b;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rs_val = 0; rt_val = 0; imm = 0; instr = 0; use_imm = 0; op_class = 0;
    mem_we = 0; mem_dst = 0; mem_val = 0; wb_we = 0; wb_dst = 0; wb_val = 0;
  endtask

  // apply the currently set inputs, run one edge, compare
  task automatic run(input string req);
    logic [31:0] a, b, e_res, e_st;
    a = pick(instr[25:21], rs_val);
    b = pick(instr[20:16], rt_val);
    e_st = b;
    e_res = model(a, use_imm ? imm : b);
    @(negedge clk);
    check({req, " result"}, res_q, e_res);
    check({req, " store"}, store_q, e_st);
  endtask

  task automatic t_reset();
    rst = 1; idle(); rs_val = 5; instr = mk(1, 2, 6'h20);
    @(negedge clk); @(negedge clk);
    check("R1 reset result", res_q, 0);
    check("R1 reset store", store_q, 0);
    rst = 0;
  endtask

  task automatic t_back_to_back();
    idle(); instr = mk(5, 6, 6'h20); op_class = 2'b10;
    rs_val = 32'h100; rt_val = 32'h7;
    mem_we = 1; mem_dst = 5; mem_val = 32'h4000;
    run("R2 mem->A");
    mem_dst = 6; run("R6 mem->B");
  endtask

  task automatic t_two_apart();
    idle(); instr = mk(9, 10, 6'h22); op_class = 2'b10;
    rs_val = 32'h50; rt_val = 32'h3;
    wb_we = 1; wb_dst = 10; wb_val = 32'h11;
    run("R6 wb->B");
    wb_dst = 9; run("R2 wb->A");
  endtask

  task automatic t_both();
    idle(); instr = mk(4, 4, 6'h25); op_class = 2'b10;
    rs_val = 32'h1; rt_val = 32'h2;
    mem_we = 1; mem_dst = 4; mem_val = 32'hF0;
    wb_we = 1; wb_dst = 4; wb_val = 32'h0F;
    run("R3 both");
    check("R3 store uses mem", store_q, 32'hF0);
  endtask

  task automatic t_zero();
    idle(); instr = mk(0, 0, 6'h20); op_class = 2'b10;
    rs_val = 32'h21; rt_val = 32'h22;
    mem_we = 1; mem_dst = 0; mem_val = 32'hDEAD;
    wb_we = 1; wb_dst = 0; wb_val = 32'hBEEF;
    run("R4 reg0");
    check("R4 store keeps reg", store_q, 32'h22);
  endtask

  task automatic t_disabled();
    idle(); instr = mk(7, 8, 6'h20); op_class = 2'b00;
    rs_val = 32'h30; rt_val = 32'h40;
    mem_dst = 7; mem_val = 32'h999; wb_dst = 8; wb_val = 32'h888;
    run("R5 we low");
    check("R5 result no bypass", res_q, 32'h70);
  endtask

  task automatic t_store();
    idle(); instr = mk(2, 3, 6'h00); op_class = 2'b00; use_imm = 1;
    rs_val = 32'h1000; rt_val = 32'h5; imm = 32'hFFFF_FFFC;
    mem_we = 1; mem_dst = 3; mem_val = 32'hCAFE;
    run("R7 store");
    check("R7 address", res_q, 32'h0FFC);
    check("R7 data", store_q, 32'hCAFE);
  endtask

  task automatic t_classes();
    idle(); instr = mk(1, 2, 6'h24); rs_val = 32'h10; rt_val = 32'h3;
    op_class = 2'b00; run("R8 class add");
    op_class = 2'b01; run("R8 class sub");
    op_class = 2'b11; run("R8 class 11");
  endtask

  task automatic t_funct();
    idle(); op_class = 2'b10; rs_val = 32'hFFFF_FFF0; rt_val = 32'h0000_00FF;
    foreach (fc_list[i]) begin
      instr = mk(1, 2, fc_list[i]);
      run("R9 funct");
    end
    instr = mk(1, 2, 6'h2A); rs_val = 32'h5; rt_val = 32'hFFFF_FFFF;
    run("R9 slt positive vs negative");
    check("R9 slt zero", res_q, 0);
  endtask

  logic [5:0] fc_list [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h07};

  task automatic t_timing();
    idle(); instr = mk(1, 2, 6'h20); op_class = 2'b10;
    rs_val = 32'h2; rt_val = 32'h3;
    run("R10 setup");
    rs_val = 32'h100; rt_val = 32'h200;
    #1;
    check("R10 hold result", res_q, 32'h5);
    check("R10 hold store", store_q, 32'h3);
    run("R10 next edge");
  endtask

  initial begin
    t_reset();
    t_back_to_back();
    t_two_apart();
    t_both();
    t_zero();
    t_disabled();
    t_store();
    t_classes();
    t_funct();
    t_timing();
    rst = 1; rs_val = 32'h77;
    @(negedge clk);
    check("R1 reset mid-run result", res_q, 0);
    check("R1 reset mid-run store", store_q, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule